// File: doc/BRIEF.md
# Line 21 Closed Caption Encoder

This block produces the serial caption waveform, as a two-level stream, that is mixed into the luma path on the caption line of each NTSC field. Software loads two 7-bit caption characters per field into four word registers. When the video timing marks the start of the caption window on line 21 (field 1) or line 284 (field 2), and that field is enabled, the block sends a clock run-in, three start bits and the field's two characters. Each character gets an odd-parity bit computed by the block.

Each field has a status flag that goes high when the field's bytes have been taken for transmission and returns low when new bytes are written. If the caption line comes round and no new bytes were written since the last send, the block sends the null character pair instead of repeating old text. Symbol timing comes from a fractional accumulator running on the pixel-rate clock, so the half-bit period averages 67/5 clocks with no rate clock of its own.

Top module: `cc_line21_enc`

## Requirements
- R1: After reset, `cc_out` and `cc_active` are 0, both status flags `sent_f1` and `sent_f2` are 1 and all word registers hold 0.
- R2: A transmission starts on a clock edge where `line_go` is 1, no transmission is running, and either `line_num` is 21 with `en_f1` set (field 1) or `line_num` is 284 with `en_f2` set (field 2); on any other line number or with the field disabled, `cc_active` stays 0.
- R3: The stream is 52 half-symbols: 14 alternating half-symbols starting with 1 (seven run-in cycles), then start bits 0, 0, 1, then 16 data bits, first character then second character, each least significant bit first; every bit after the run-in lasts two half-symbols.
- R4: Each character is 8 bits: bits 6:0 from the word register, bit 7 set so the byte has an odd number of ones.
- R5: With n counting clock edges after the start edge (n = 0 right after it), the half-symbol shown is floor(5n/67) and `cc_active` is 1 exactly for n < 697.
- R6: A write (`wr_en`) to `wr_sel` 0 or 1 loads field 1 character 1 or 2, to 2 or 3 loads field 2 character 1 or 2, and clears that field's status flag on the next edge; the other field's flag is unaffected.
- R7: A field's status flag is set on the edge its transmission starts; a write to that field in the same cycle wins and leaves the flag clear.
- R8: When the field's flag is clear at the start edge the stored characters are sent; when it is set, both characters are sent as the null byte 0x80.
- R9: `line_go` pulses while a transmission runs are ignored and do not restart or lengthen it.
- R10: `cc_out` is 0 whenever `cc_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_go | input | 1 | One-cycle pulse at the start of the caption window of a line |
| line_num | input | 10 | Current line number of the 525-line frame |
| en_f1 | input | 1 | Enable caption sending in field 1 |
| en_f2 | input | 1 | Enable caption sending in field 2 |
| wr_en | input | 1 | Word register write strobe |
| wr_sel | input | 2 | Word register select (field in bit 1, character in bit 0) |
| wr_data | input | 7 | Caption character to store |
| cc_out | output | 1 | Serial caption level |
| cc_active | output | 1 | High while a caption line is being sent |
| sent_f1 | output | 1 | Field 1 bytes taken for sending, no new bytes since |
| sent_f2 | output | 1 | Field 2 bytes taken for sending, no new bytes since |

## Verification
A wrong accumulator residue or half-symbol counter shows as a symbol edge displaced by one clock, seen within the first few symbols, or as an active window that ends off the 697-clock mark on the very first line. A wrong status flag shows only on the next caption line of that field, as stored text where nulls were due or the reverse, so the bench runs several lines per field with writes placed between, before and at the start edge. Parity or bit-order faults appear in the data half of every line that carries a non-null character.

// File: rtl/cc_line21_enc.sv
module cc_line21_enc #(
  parameter int LINE_W       = 10,
  parameter int LINE_F1      = 21,
  parameter int LINE_F2      = 284,
  parameter int HALF_NUM     = 67,
  parameter int HALF_DEN     = 5,
  parameter int RUNIN_HALVES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_go,
  input  logic [LINE_W-1:0] line_num,
  input  logic              en_f1,
  input  logic              en_f2,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [6:0]        wr_data,
  output logic              cc_out,
  output logic              cc_active,
  output logic              sent_f1,
  output logic              sent_f2
);
  localparam int SYMS  = RUNIN_HALVES + 2 * (3 + 16);
  localparam int IDX_W = $clog2(SYMS + 1);
  localparam int ACC_W = $clog2(HALF_NUM + HALF_DEN + 1);

  logic [6:0]       word_q [4];
  logic [1:0]       sent_q;
  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] acc;
  logic [15:0]      pay;

  wire hit1  = line_go && !busy && en_f1 && (line_num == LINE_W'(LINE_F1));
  wire hit2  = line_go && !busy && en_f2 && (line_num == LINE_W'(LINE_F2));
  wire start = hit1 || hit2;

  wire [ACC_W-1:0] acc_nx = acc + ACC_W'(HALF_DEN);
  wire             tick   = acc_nx >= ACC_W'(HALF_NUM);
  wire             last   = idx == IDX_W'(SYMS - 1);

  wire       fresh = hit1 ? !sent_q[0] : !sent_q[1];
  wire [6:0] c1    = fresh ? (hit1 ? word_q[0] : word_q[2]) : 7'h00;
  wire [6:0] c2    = fresh ? (hit1 ? word_q[1] : word_q[3]) : 7'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) word_q[i] <= '0;
    end else if (wr_en) begin
      word_q[wr_sel] <= wr_data;
    end
  end

  for (genvar f = 0; f < 2; f++) begin : g_stat
    wire own_wr  = wr_en && (wr_sel[1] == f[0]);
    wire own_hit = (f == 0) ? hit1 : hit2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sent_q[f] <= 1'b1;
      else if (own_wr)  sent_q[f] <= 1'b0;
      else if (own_hit) sent_q[f] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      acc  <= '0;
      pay  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      acc  <= '0;
      pay  <= {~^c2, c2, ~^c1, c1};
    end else if (busy) begin
      acc <= tick ? acc_nx - ACC_W'(HALF_NUM) : acc_nx;
      if (tick) begin
        if (last) busy <= 1'b0;
        idx <= idx + 1'b1;
      end
    end
  end

  logic [IDX_W-1:0] dpos;
  logic [IDX_W-2:0] bitn;
  logic [IDX_W-1:0] pidx;
  logic             sym;

  always_comb begin
    dpos = idx - IDX_W'(RUNIN_HALVES);
    bitn = dpos[IDX_W-1:1];
    pidx = IDX_W'(bitn) - IDX_W'(3);
    if (idx < IDX_W'(RUNIN_HALVES)) sym = ~idx[0];
    else if (bitn < 2)              sym = 1'b0;
    else if (bitn == 2)             sym = 1'b1;
    else                            sym = pay[pidx[3:0]];
  end

  assign cc_out    = busy && sym;
  assign cc_active = busy;
  assign sent_f1   = sent_q[0];
  assign sent_f2   = sent_q[1];

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_active |-> !cc_out);
  assert_runin_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_active) |-> cc_out);
  assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_go && !cc_active && en_f1 && line_num == LINE_W'(LINE_F1)) |=> (cc_active && $rose(cc_active)));
  assert_wr_clears_f1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel[1]) |=> !sent_f1);
  assert_wr_clears_f2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[1]) |=> !sent_f2);
  assert_start_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cc_active) && !$past(wr_en) && $past(line_num) == LINE_W'(LINE_F2)) |-> sent_f2);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_active && $past(cc_active)) |-> $stable(sent_f1) || $past(wr_en));
endmodule

// File: tb/cc_line21_enc_bench.sv
`timescale 1ns/1ps
module cc_line21_enc_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       line_go = 0;
  logic [9:0] line_num = 0;
  logic       en_f1 = 0, en_f2 = 0;
  logic       wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [6:0] wr_data = 0;
  logic       cc_out, cc_active, sent_f1, sent_f2;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [6:0] m_word [4];
  bit         m_sent [2];

  always #2 clk = ~clk;

  cc_line21_enc u_cc_line21_enc (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .line_num(line_num),
    .en_f1(en_f1), .en_f2(en_f2), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cc_out(cc_out), .cc_active(cc_active),
    .sent_f1(sent_f1), .sent_f2(sent_f2));

  function automatic logic [7:0] with_par(input logic [6:0] c);
    return {~^c, c};
  endfunction

  function automatic logic exp_sym(input int k, input logic [6:0] c1, input logic [6:0] c2);
    logic [15:0] p;
    int b;
    p = {with_par(c2), with_par(c1)};
    if (k < 14) return (k % 2) == 0;
    b = (k - 14) / 2;
    if (b < 2) return 1'b0;
    if (b == 2) return 1'b1;
    return p[b-3];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [1:0] sel, input logic [6:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    m_word[sel] = d;
    m_sent[sel[1]] = 0;
    check("R6 flag of written field", sel[1] ? sent_f2 : sent_f1, 0);
  endtask

  // Runs one line; go_mid re-pulses line_go mid-line (R9); wr_same writes at the start edge (R7)
  task automatic run_line(input int ln, input bit e1, input bit e2,
                          input bit go_mid, input bit wr_same, input logic [1:0] ws,
                          input logic [6:0] wd);
    bit starts; int f; logic [6:0] c1, c2; int bad_n; int bad_a; int bad_e;
    f = (ln == 284) ? 1 : 0;
    starts = (ln == 21 && e1) || (ln == 284 && e2);
    c1 = 0; c2 = 0;
    if (starts && !m_sent[f]) begin c1 = m_word[2*f]; c2 = m_word[2*f+1]; end
    @(negedge clk);
    en_f1 = e1; en_f2 = e2; line_num = 10'(ln); line_go = 1;
    if (wr_same) begin wr_en = 1; wr_sel = ws; wr_data = wd; end
    @(posedge clk);
    @(negedge clk);
    line_go = 0; wr_en = 0;
    if (starts) m_sent[f] = 1;
    if (wr_same) begin m_word[ws] = wd; m_sent[ws[1]] = 0; end
    bad_n = -1; bad_a = 0; bad_e = 0;
    for (int n = 0; n < 710; n++) begin
      int k; int ea; int eo;
      if (n > 0) begin
        if (go_mid && n == 100) line_go = 1;
        @(posedge clk);
        @(negedge clk);
        line_go = 0;
      end
      k = (n * 5) / 67;
      ea = starts && (k < 52);
      eo = ea ? exp_sym(k, c1, c2) : 0;
      if (bad_n < 0 && ({cc_active, cc_out} != {ea[0], eo[0]})) begin
        bad_n = n; bad_a = {cc_active, cc_out}; bad_e = {ea[0], eo[0]};
      end
    end
    checks++;
    if (bad_n >= 0) begin
      errors++;
      $display("FAIL R2 R3 R4 R5 R8 R9 R10 line %0d at n=%0d: actual {act,out}=%0d expected %0d",
               ln, bad_n, bad_a, bad_e);
    end
    check("R7 sent_f1", sent_f1, m_sent[0]);
    check("R7 sent_f2", sent_f2, m_sent[1]);
  endtask

  initial begin
    int unsigned s;
    for (int i = 0; i < 4; i++) m_word[i] = 0;
    m_sent[0] = 1; m_sent[1] = 1;
    s = $urandom(32'd2024);
    #9 rst_n = 1;
    @(negedge clk);
    check("R1 cc_active", cc_active, 0);
    check("R1 cc_out", cc_out, 0);
    check("R1 sent_f1", sent_f1, 1);
    check("R1 sent_f2", sent_f2, 1);
    // R8 nulls before any write
    run_line(21, 1, 1, 0, 0, 0, 0);
    // R3 R4 directed characters
    write_word(0, 7'h41); write_word(1, 7'h7F);
    write_word(2, 7'h00); write_word(3, 7'h2A);
    check("R6 f2 independent of f1 write", sent_f1, 0);
    run_line(21, 1, 1, 0, 0, 0, 0);
    run_line(284, 1, 1, 0, 0, 0, 0);
    // R8 repeat without new bytes sends nulls
    run_line(21, 1, 1, 0, 0, 0, 0);
    // R2 disabled field and wrong line
    write_word(0, 7'h55);
    run_line(21, 0, 1, 0, 0, 0, 0);
    run_line(22, 1, 1, 0, 0, 0, 0);
    run_line(284, 1, 0, 0, 0, 0, 0);
    // R9 go during line ignored
    run_line(21, 1, 1, 1, 0, 0, 0);
    // R7 write on start edge: nulls now, new text next time
    run_line(21, 1, 1, 0, 1, 2'd1, 7'h33);
    run_line(21, 1, 1, 0, 0, 0, 0);
    // constrained random
    for (int it = 0; it < 24; it++) begin
      int nw; int r; int ln;
      nw = $urandom % 3;
      for (int w = 0; w < nw; w++) write_word(2'($urandom), 7'($urandom));
      r = $urandom % 4;
      ln = (r == 1) ? 284 : (r == 2) ? 30 + ($urandom % 200) : 21;
      run_line(ln, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) == 0, 0, 0, 0);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule